// File: doc/BRIEF.md
# Decode-Stage Branch Resolver

This unit settles conditional equal-compare branches while the branch is still in the decode stage of a five-stage pipeline. A dedicated adder forms the branch destination and an equality comparator decides the outcome in the same cycle. When the branch is taken, the unit steers the program counter to the destination and squashes the single instruction already fetched behind it. When a comparison operand is still being produced further down the pipe, the unit holds the branch in decode instead.

The surrounding pipeline feeds it the decode-stage branch flag, the two source register numbers, and the operand values already chosen by the operand multiplexers. It also supplies the raw sign-extended offset, the address of the following instruction, and a destination, write-enable and load flag from each of the execute and memory stages. It returns a next-PC select, the destination address, a flush for the fetch/decode register, a stall, and one forward-select code per operand that the comparator multiplexers outside the block use. A stall means three things: hold the PC, hold the fetch/decode register, and issue a zero-control bubble into execute.

Top module: `branch_resolver`

## Requirements
- R1: `br_target` always equals `next_pc + (offset << 2)` modulo 2^XLEN, with a negative offset moving backwards. For example, next_pc 44 with offset 7 gives 72.
- R2: When `br_valid` is 1, no stall is raised and `opnd_a == opnd_b`, then `pc_redirect` and `fd_flush` are both 1 in the same cycle.
- R3: When `br_valid` is 1 and the operands differ, `pc_redirect` and `fd_flush` are 0.
- R4: An execute-stage instruction with `ex_wr`=1, `ex_load`=0 and a nonzero `ex_dest` equal to `src_a` or `src_b` raises `stall`. While `stall` is 1, `pc_redirect` and `fd_flush` are 0.
- R5: A load (`*_load`=1, `*_wr`=1) whose nonzero destination matches a source raises `stall`, whether it sits in execute or in memory. A load directly ahead of the branch therefore holds it for two cycles as it moves down the pipe.
- R6: A memory-stage non-load writer with nonzero `mem_dest` matching an operand's source, while no execute-stage writer matches that source, sets that operand's forward select to 2'b01 and raises no stall. Otherwise the select is 2'b00, meaning register file.
- R7: A destination of register 0 never raises `stall` and never gives a forward select of 2'b01.
- R8: With `br_valid` at 0, `stall`, `pc_redirect` and `fd_flush` are 0 and both forward selects are 2'b00, whatever the stage flags hold.
- R9: A stage whose write flag is 0 never raises `stall`, even when its destination matches a source.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| br_valid | input | 1 | Decode stage holds an equal-compare branch |
| src_a | input | REGW | First comparison register number |
| src_b | input | REGW | Second comparison register number |
| opnd_a | input | XLEN | First comparison value, after outside muxing |
| opnd_b | input | XLEN | Second comparison value, after outside muxing |
| offset | input | XLEN | Sign-extended word offset |
| next_pc | input | XLEN | Address of the instruction after the branch |
| ex_dest | input | REGW | Execute-stage destination register |
| ex_wr | input | 1 | Execute-stage instruction writes a register |
| ex_load | input | 1 | Execute-stage instruction is a load |
| mem_dest | input | REGW | Memory-stage destination register |
| mem_wr | input | 1 | Memory-stage instruction writes a register |
| mem_load | input | 1 | Memory-stage instruction is a load |
| pc_redirect | output | 1 | Select branch destination as next PC |
| br_target | output | XLEN | Branch destination address |
| fd_flush | output | 1 | Zero the control of the fetch/decode entry |
| stall | output | 1 | Hold PC and fetch/decode; bubble into execute |
| fwd_a | output | 2 | Forward select for first operand (00 regfile, 01 memory stage) |
| fwd_b | output | 2 | Forward select for second operand |

## Verification
Every output depends only on the inputs of the current cycle, so a wrong decision appears at the ports in the same cycle as the stimulus. A hazard term matched against the wrong stage shows up as a missing or extra stall, and a missing stall lets a redirect through on stale data. A wrong priority between stages shows up as a forward select of 01 while an execute-stage writer still owns the register. Multi-cycle checks advance a load or an ALU result through the modelled stage flags, and confirm that the stall lasts exactly two cycles for a load and one cycle for an ALU result.

// File: rtl/brres_pkg.sv
package brres_pkg;

    parameter int XLEN = 32;
    parameter int REGW = 5;
    localparam int NUM_OPND = 2;
    localparam int SHAMT    = 2;

    typedef enum logic [1:0] {
        FWD_REGFILE  = 2'b00,
        FWD_MEMSTAGE = 2'b01
    } fwd_src_e;

    typedef struct packed {
        logic [REGW-1:0] dest;
        logic            wr;
        logic            load;
    } stage_t;

    // True when the stage will write register r and r is not the zero register
    function automatic logic stage_writes(stage_t s, logic [REGW-1:0] r);
        return s.wr && (s.dest != '0) && (s.dest == r);
    endfunction

endpackage

// File: rtl/br_target_calc.sv
module br_target_calc
    import brres_pkg::*;
#(
    parameter int W = XLEN
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] next_pc,
    input  logic [W-1:0] offset,
    output logic [W-1:0] target
);
    logic [W-1:0] byte_off;

    always_comb begin
        byte_off = offset << SHAMT;
        target   = next_pc + byte_off;
    end

    // R1: word-scaled offset never changes the low address bits
    a_r1_word_aligned: assert property (@(posedge clk) disable iff (rst)
        target[SHAMT-1:0] == next_pc[SHAMT-1:0]);

endmodule

// File: rtl/br_operand_hazard.sv
module br_operand_hazard
    import brres_pkg::*;
(
    input  logic            clk,
    input  logic            rst,
    input  logic            br_valid,
    input  logic [REGW-1:0] src,
    input  stage_t          ex_st,
    input  stage_t          mem_st,
    output logic            need_stall,
    output fwd_src_e        fwd
);
    logic ex_hit;
    logic mem_hit;

    always_comb begin
        ex_hit     = stage_writes(ex_st, src);
        mem_hit    = stage_writes(mem_st, src);
        need_stall = br_valid && (ex_hit || (mem_hit && mem_st.load));
        fwd        = (br_valid && mem_hit && !mem_st.load && !ex_hit)
                     ? FWD_MEMSTAGE : FWD_REGFILE;
    end

    // R7: register zero is never a hazard source
    a_r7_zero_reg: assert property (@(posedge clk) disable iff (rst)
        (src == '0) |-> (!need_stall && fwd == FWD_REGFILE));

    // R9: a non-writing stage can never hold the branch
    a_r9_no_write: assert property (@(posedge clk) disable iff (rst)
        (!ex_st.wr && !mem_st.wr) |-> !need_stall);

endmodule

// File: rtl/br_compare.sv
module br_compare
    import brres_pkg::*;
#(
    parameter int W = XLEN
) (
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    output logic         equal
);
    logic [W-1:0] diff;

    always_comb begin
        diff  = a ^ b;
        equal = (diff == '0);
    end

endmodule

// File: rtl/branch_resolver.sv
module branch_resolver
    import brres_pkg::*;
(
    input  logic            clk,
    input  logic            rst,
    input  logic            br_valid,
    input  logic [REGW-1:0] src_a,
    input  logic [REGW-1:0] src_b,
    input  logic [XLEN-1:0] opnd_a,
    input  logic [XLEN-1:0] opnd_b,
    input  logic [XLEN-1:0] offset,
    input  logic [XLEN-1:0] next_pc,
    input  logic [REGW-1:0] ex_dest,
    input  logic            ex_wr,
    input  logic            ex_load,
    input  logic [REGW-1:0] mem_dest,
    input  logic            mem_wr,
    input  logic            mem_load,
    output logic            pc_redirect,
    output logic [XLEN-1:0] br_target,
    output logic            fd_flush,
    output logic            stall,
    output logic [1:0]      fwd_a,
    output logic [1:0]      fwd_b
);
    stage_t                ex_st;
    stage_t                mem_st;
    logic [REGW-1:0]       src_v   [NUM_OPND];
    logic [NUM_OPND-1:0]   opnd_stall;
    fwd_src_e              fwd_v   [NUM_OPND];
    logic                  opnd_eq;

    always_comb begin
        ex_st    = '{dest: ex_dest,  wr: ex_wr,  load: ex_load};
        mem_st   = '{dest: mem_dest, wr: mem_wr, load: mem_load};
        src_v[0] = src_a;
        src_v[1] = src_b;
    end

    for (genvar k = 0; k < NUM_OPND; k++) begin : g_opnd
        br_operand_hazard u_haz (
            .clk        (clk),
            .rst        (rst),
            .br_valid   (br_valid),
            .src        (src_v[k]),
            .ex_st      (ex_st),
            .mem_st     (mem_st),
            .need_stall (opnd_stall[k]),
            .fwd        (fwd_v[k])
        );
    end

    br_target_calc #(.W(XLEN)) u_tgt (
        .clk     (clk),
        .rst     (rst),
        .next_pc (next_pc),
        .offset  (offset),
        .target  (br_target)
    );

    br_compare #(.W(XLEN)) u_cmp (
        .a     (opnd_a),
        .b     (opnd_b),
        .equal (opnd_eq)
    );

    always_comb begin
        stall       = |opnd_stall;
        pc_redirect = br_valid && !stall && opnd_eq;
        fd_flush    = pc_redirect;
        fwd_a       = fwd_v[0];
        fwd_b       = fwd_v[1];
    end

    // R4: a held branch neither redirects nor squashes
    a_r4_stall_blocks: assert property (@(posedge clk) disable iff (rst)
        stall |-> (!pc_redirect && !fd_flush));

    // R2: a squash only follows equal operands of a real branch
    a_r2_flush_cause: assert property (@(posedge clk) disable iff (rst)
        fd_flush |-> (br_valid && opnd_a == opnd_b));

    // R8: without a branch the unit is silent
    a_r8_idle: assert property (@(posedge clk) disable iff (rst)
        !br_valid |-> (!stall && !pc_redirect && fwd_a == 2'b00 && fwd_b == 2'b00));

    // R6: a memory-stage forward never coexists with a load there
    a_r6_fwd_alu_only: assert property (@(posedge clk) disable iff (rst)
        (fwd_a == 2'b01 || fwd_b == 2'b01) |-> (mem_wr && !mem_load));

endmodule

// File: tb/branch_resolver_bench.sv
module branch_resolver_bench;
    localparam int XW = 32;
    localparam int RW = 5;
    localparam int NV = 14;

    typedef struct packed {
        logic          br;
        logic [RW-1:0] ra, rb;
        logic [XW-1:0] va, vb, off, npc;
        logic [RW-1:0] exd;
        logic          exw, exl;
        logic [RW-1:0] md;
        logic          mw, ml;
        logic          e_take, e_stall;
        logic [1:0]    e_fa, e_fb;
    } vec_t;

    localparam vec_t VT [NV] = '{
        '{1'b1,5'd1,5'd3,32'd5,32'd5,32'd7,32'd44,5'd0,1'b0,1'b0,5'd0,1'b0,1'b0,1'b1,1'b0,2'd0,2'd0},
        '{1'b1,5'd1,5'd3,32'd5,32'd6,32'd7,32'd44,5'd0,1'b0,1'b0,5'd0,1'b0,1'b0,1'b0,1'b0,2'd0,2'd0},
        '{1'b1,5'd1,5'd3,32'd5,32'd5,32'd2,32'd8,5'd1,1'b1,1'b0,5'd0,1'b0,1'b0,1'b0,1'b1,2'd0,2'd0},
        '{1'b1,5'd1,5'd3,32'd5,32'd5,32'd2,32'd8,5'd3,1'b1,1'b0,5'd0,1'b0,1'b0,1'b0,1'b1,2'd0,2'd0},
        '{1'b1,5'd1,5'd3,32'd5,32'd5,32'd2,32'd8,5'd3,1'b1,1'b1,5'd0,1'b0,1'b0,1'b0,1'b1,2'd0,2'd0},
        '{1'b1,5'd1,5'd3,32'd5,32'd5,32'd2,32'd8,5'd0,1'b0,1'b0,5'd1,1'b1,1'b1,1'b0,1'b1,2'd0,2'd0},
        '{1'b1,5'd1,5'd3,32'd9,32'd9,32'd4,32'd20,5'd0,1'b0,1'b0,5'd1,1'b1,1'b0,1'b1,1'b0,2'd1,2'd0},
        '{1'b1,5'd1,5'd3,32'd9,32'd8,32'd4,32'd20,5'd0,1'b0,1'b0,5'd3,1'b1,1'b0,1'b0,1'b0,2'd0,2'd1},
        '{1'b1,5'd0,5'd3,32'd0,32'd0,32'd1,32'd12,5'd0,1'b1,1'b0,5'd0,1'b1,1'b0,1'b1,1'b0,2'd0,2'd0},
        '{1'b1,5'd2,5'd0,32'd3,32'd4,32'd1,32'd12,5'd0,1'b1,1'b1,5'd0,1'b1,1'b1,1'b0,1'b0,2'd0,2'd0},
        '{1'b0,5'd1,5'd3,32'd5,32'd5,32'd1,32'd12,5'd1,1'b1,1'b1,5'd3,1'b1,1'b0,1'b0,1'b0,2'd0,2'd0},
        '{1'b1,5'd1,5'd3,32'd5,32'd5,32'd1,32'd12,5'd1,1'b0,1'b0,5'd3,1'b0,1'b1,1'b1,1'b0,2'd0,2'd0},
        '{1'b1,5'd6,5'd7,32'd1,32'd1,32'hFFFF_FFFD,32'd100,5'd0,1'b0,1'b0,5'd0,1'b0,1'b0,1'b1,1'b0,2'd0,2'd0},
        '{1'b1,5'd1,5'd3,32'd5,32'd5,32'd1,32'd12,5'd1,1'b1,1'b0,5'd1,1'b1,1'b0,1'b0,1'b1,2'd0,2'd0}
    };
    // Main requirement of each vector
    localparam string VTAG [NV] = '{"R2","R3","R4","R4","R5","R5","R6","R6",
                                    "R7","R7","R8","R9","R1","R6"};

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic br_valid = 1'b0;
    logic [RW-1:0] src_a = '0, src_b = '0, ex_dest = '0, mem_dest = '0;
    logic [XW-1:0] opnd_a = '0, opnd_b = '0, offset = '0, next_pc = '0;
    logic ex_wr = 1'b0, ex_load = 1'b0, mem_wr = 1'b0, mem_load = 1'b0;
    logic pc_redirect, fd_flush, stall;
    logic [XW-1:0] br_target;
    logic [1:0] fwd_a, fwd_b;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    branch_resolver u_branch_resolver (
        .clk(clk), .rst(rst), .br_valid(br_valid),
        .src_a(src_a), .src_b(src_b), .opnd_a(opnd_a), .opnd_b(opnd_b),
        .offset(offset), .next_pc(next_pc),
        .ex_dest(ex_dest), .ex_wr(ex_wr), .ex_load(ex_load),
        .mem_dest(mem_dest), .mem_wr(mem_wr), .mem_load(mem_load),
        .pc_redirect(pc_redirect), .br_target(br_target), .fd_flush(fd_flush),
        .stall(stall), .fwd_a(fwd_a), .fwd_b(fwd_b)
    );

    task automatic chk(string tag, string what, logic [XW-1:0] act, logic [XW-1:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
        end
    endtask

    task automatic set_stages(logic [RW-1:0] ed, logic ew, logic el,
                              logic [RW-1:0] mdst, logic mwr, logic mld);
        ex_dest = ed; ex_wr = ew; ex_load = el;
        mem_dest = mdst; mem_wr = mwr; mem_load = mld;
    endtask

    initial begin
        #2_000_000;
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual running expected finished");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        int stalls;
        repeat (3) @(negedge clk);
        #5;
        // R8: idle during reset
        chk("R8", "reset stall", {31'd0, stall}, 32'd0);
        chk("R8", "reset redirect", {31'd0, pc_redirect}, 32'd0);
        chk("R8", "reset flush", {31'd0, fd_flush}, 32'd0);
        @(negedge clk);
        rst = 1'b0;

        for (int i = 0; i < NV; i++) begin
            @(negedge clk);
            br_valid = VT[i].br; src_a = VT[i].ra; src_b = VT[i].rb;
            opnd_a = VT[i].va; opnd_b = VT[i].vb;
            offset = VT[i].off; next_pc = VT[i].npc;
            set_stages(VT[i].exd, VT[i].exw, VT[i].exl, VT[i].md, VT[i].mw, VT[i].ml);
            #5;
            chk(VTAG[i], "redirect", {31'd0, pc_redirect}, {31'd0, VT[i].e_take});
            chk(VTAG[i], "flush", {31'd0, fd_flush}, {31'd0, VT[i].e_take});
            chk(VTAG[i], "stall", {31'd0, stall}, {31'd0, VT[i].e_stall});
            chk(VTAG[i], "fwd_a", {30'd0, fwd_a}, {30'd0, VT[i].e_fa});
            chk(VTAG[i], "fwd_b", {30'd0, fwd_b}, {30'd0, VT[i].e_fb});
            // R1: destination formula on every vector
            chk("R1", "target", br_target, VT[i].npc + (VT[i].off << 2));
        end

        // R5: load directly ahead of the branch holds it two cycles
        @(negedge clk);
        br_valid = 1'b1; src_a = 5'd4; src_b = 5'd9; opnd_a = 32'd3; opnd_b = 32'd3;
        offset = 32'd7; next_pc = 32'd44;
        stalls = 0;
        set_stages(5'd4, 1'b1, 1'b1, 5'd0, 1'b0, 1'b0);
        #5; if (stall) stalls++;
        chk("R5", "no redirect while load in execute", {31'd0, pc_redirect}, 32'd0);
        @(negedge clk);
        set_stages(5'd0, 1'b0, 1'b0, 5'd4, 1'b1, 1'b1);
        #5; if (stall) stalls++;
        @(negedge clk);
        set_stages(5'd0, 1'b0, 1'b0, 5'd0, 1'b0, 1'b0);
        #5; if (stall) stalls++;
        chk("R5", "load stall cycles", stalls, 32'd2);
        chk("R2", "redirect after load stall", {31'd0, pc_redirect}, 32'd1);
        chk("R1", "target 44+7*4", br_target, 32'd72);

        // R4 and R6: ALU result directly ahead holds one cycle, then forwards
        @(negedge clk);
        stalls = 0;
        src_a = 5'd2; src_b = 5'd4; opnd_a = 32'd1; opnd_b = 32'd2;
        set_stages(5'd4, 1'b1, 1'b0, 5'd0, 1'b0, 1'b0);
        #5; if (stall) stalls++;
        @(negedge clk);
        set_stages(5'd0, 1'b0, 1'b0, 5'd4, 1'b1, 1'b0);
        #5; if (stall) stalls++;
        chk("R4", "ALU stall cycles", stalls, 32'd1);
        chk("R6", "fwd_b after ALU stall", {30'd0, fwd_b}, 32'd1);
        chk("R3", "unequal no flush", {31'd0, fd_flush}, 32'd0);

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule